// File: doc/BRIEF.md
# Switchable infrared serial line encoder/decoder

This block sits between a UART's serial bit streams and the chip's serial pins. In direct mode the transmit and receive streams pass straight through. In infrared mode the transmit stream goes through a pulse encoder and the receive stream through a pulse decoder. The encoder marks each zero bit with a short high pulse, and the decoder rebuilds an idle-high bit stream from incoming pulses. Timing within a bit comes from a 16x baud-rate enable tick that the baud generator supplies.

The mode bit starts from a strap input, which is sampled on the first clock after reset is released. A one-cycle write strobe from the host register file can then set or clear the mode bit at any time. Two further configuration inputs act on the infrared receive path. One inverts the receive pin before it reaches the decoder, for optical modules whose output is active-low. The other is a half-duplex gate: while the transmitter reports busy, it forces the recovered receive stream to idle, so the block's own optical echo is not decoded.

Top module: `ir_line_switch`

## Requirements
- R1: While reset is asserted and until the first clock edge after the internal (synchronously released) reset goes high, the mode bit is 0 (direct). On that first edge it loads `strap_ir_i` (1 = infrared), unless a write happens in the same cycle.
- R2: When `cfg_mode_we_i` is high at a clock edge, the mode bit takes the value of `cfg_mode_i` (1 = infrared, 0 = direct) on that edge. This overrides the strap value in either direction, and `mode_o` shows the new value after the edge.
- R3: In direct mode `pin_txd_o` equals `uart_txd_i` and `uart_rxd_o` equals `pin_rxd_i`. There is no encoding, no inversion and no blanking.
- R4: In infrared mode a bit cell is 16 ticks long. Tick index 0 is the first tick at which `uart_txd_i` shows a level that differs from the previous cell's level; without a change, the index wraps from 15 to 0. In a cell where `uart_txd_i` is 0, `pin_txd_o` is high after the ticks with index 8, 9 and 10 and low after every other tick of the cell. In a cell where `uart_txd_i` is 1, no pulse is produced.
- R5: In infrared mode `pin_txd_o` is 0 while the UART transmit line is idle (high).
- R6: In infrared mode the receive pin passes through a two-stage synchroniser and is sampled on each tick. A rising level seen at tick t drives `uart_rxd_o` low from tick t through tick t+15. Otherwise `uart_rxd_o` is 1.
- R7: Pulses that arrive 16 ticks apart keep `uart_rxd_o` low without a break, so a run of zero bits decodes as one continuous low level.
- R8: With `cfg_rx_inv_i` = 1, the receive pin is inverted before the decoder: the line idles high and pulses are low. Decoding is otherwise the same as R6.
- R9: In infrared mode with `cfg_half_dup_i` = 1 and `tx_busy_i` = 1, `uart_rxd_o` is 1 in the same cycle, and any low bit being held is discarded. With `cfg_half_dup_i` = 0, `tx_busy_i` has no effect.
- R10: Clearing the mode bit cancels an encoder pulse in progress: `pin_txd_o` follows `uart_txd_i` from the next edge. On a return to infrared mode with the transmit line idle, `pin_txd_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick16_i | input | 1 | Enable pulse at 16 times the bit rate |
| strap_ir_i | input | 1 | Strap giving the mode after reset (1 = infrared) |
| cfg_mode_we_i | input | 1 | Write strobe for the mode bit |
| cfg_mode_i | input | 1 | Mode value to write (1 = infrared) |
| cfg_rx_inv_i | input | 1 | Invert the receive pin ahead of the decoder |
| cfg_half_dup_i | input | 1 | Blank the receive path while the transmitter is busy |
| tx_busy_i | input | 1 | Transmitter is sending a frame |
| uart_txd_i | input | 1 | Serial transmit stream from the UART |
| uart_rxd_o | output | 1 | Serial receive stream to the UART |
| pin_txd_o | output | 1 | Transmit pin |
| pin_rxd_i | input | 1 | Receive pin |
| mode_o | output | 1 | Current mode bit (1 = infrared) |

## Verification
The assertions check on every cycle that the strap is loaded after reset and that writes to the mode bit take effect. They also check the pass-through in direct mode, a low transmit pin after ticks with an idle line, a limit of three ticks on any transmit pulse, and that the receive output is forced high while blanked. Only the bench scenarios can show the placement of each pulse within its bit cell, decoding across runs of zero bits with and without inversion, and that a held low bit is thrown away when blanking starts. They also cover the encoder staying quiet after the mode is cleared and set again.

// File: rtl/irls_pkg.sv
`timescale 1ns/1ps
package irls_pkg;
  localparam int DEF_TICKS_PER_BIT = 16;
  localparam int DEF_PULSE_START   = 8;
  localparam int DEF_PULSE_LEN     = 3;
  localparam int DEF_SYNC_STAGES   = 2;

  typedef enum logic {
    LINE_DIRECT = 1'b0,
    LINE_IR     = 1'b1
  } line_mode_e;
endpackage

// File: rtl/irls_mode_ctl.sv
`timescale 1ns/1ps
module irls_mode_ctl
  import irls_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       strap_i,
  input  logic       wr_en_i,
  input  logic       wr_val_i,
  output line_mode_e mode_o
);
  line_mode_e mode_q, mode_d;
  logic       load_pend_q, load_pend_d;

  // The strap is taken on the first edge out of reset, not as an async load value
  always_comb begin
    mode_d      = mode_q;
    load_pend_d = 1'b0;
    if (wr_en_i) begin
      mode_d = line_mode_e'(wr_val_i);
    end else if (load_pend_q) begin
      mode_d = line_mode_e'(strap_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= LINE_DIRECT;
      load_pend_q <= 1'b1;
    end else begin
      mode_q      <= mode_d;
      load_pend_q <= load_pend_d;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/irls_pulse_enc.sv
`timescale 1ns/1ps
module irls_pulse_enc #(
  parameter int TICKS_PER_BIT = irls_pkg::DEF_TICKS_PER_BIT,
  parameter int PULSE_START   = irls_pkg::DEF_PULSE_START,
  parameter int PULSE_LEN     = irls_pkg::DEF_PULSE_LEN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic bit_i,
  output logic pulse_o
);
  localparam int PW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [PW-1:0] LAST_PH = PW'(TICKS_PER_BIT - 1);
  localparam int PULSE_END = PULSE_START + PULSE_LEN;

  logic [PW-1:0] phase_q, phase_d;
  logic          level_q, level_d;
  logic          pulse_q, pulse_d;

  always_comb begin
    phase_d = phase_q;
    level_d = level_q;
    pulse_d = pulse_q;
    if (!en_i) begin
      // Leaving the mode drops any pulse and re-arms at idle level
      phase_d = '0;
      level_d = 1'b1;
      pulse_d = 1'b0;
    end else if (tick_i) begin
      if (bit_i != level_q) begin
        phase_d = '0;
      end else if (phase_q == LAST_PH) begin
        phase_d = '0;
      end else begin
        phase_d = phase_q + PW'(1);
      end
      level_d = bit_i;
      pulse_d = !bit_i && (int'(phase_d) >= PULSE_START) && (int'(phase_d) < PULSE_END);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      level_q <= 1'b1;
      pulse_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      level_q <= level_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/irls_pulse_dec.sv
`timescale 1ns/1ps
module irls_pulse_dec #(
  parameter int TICKS_PER_BIT = irls_pkg::DEF_TICKS_PER_BIT,
  parameter int SYNC_STAGES   = irls_pkg::DEF_SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic blank_i,
  input  logic tick_i,
  input  logic line_i,
  output logic bit_o
);
  localparam int CW = $clog2(TICKS_PER_BIT + 1);
  localparam logic [CW-1:0] HOLD_FULL = CW'(TICKS_PER_BIT);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   smp;
  logic [CW-1:0]          hold_q, hold_d;
  logic                   prev_q, prev_d;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= line_i;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      end
    end
  endgenerate

  assign smp = sync_q[SYNC_STAGES-1];

  always_comb begin
    hold_d = hold_q;
    prev_d = prev_q;
    if (!en_i || blank_i) begin
      // Track the line so a pulse straddling the blank is not taken as new
      hold_d = '0;
      prev_d = smp;
    end else if (tick_i) begin
      prev_d = smp;
      if (smp && !prev_q) begin
        hold_d = HOLD_FULL;
      end else if (hold_q != '0) begin
        hold_d = hold_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      prev_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      prev_q <= prev_d;
    end
  end

  assign bit_o = (hold_q == '0);
endmodule

// File: rtl/ir_line_switch.sv
`timescale 1ns/1ps
module ir_line_switch
  import irls_pkg::*;
#(
  parameter int TICKS_PER_BIT = DEF_TICKS_PER_BIT,
  parameter int PULSE_START   = DEF_PULSE_START,
  parameter int PULSE_LEN     = DEF_PULSE_LEN,
  parameter int SYNC_STAGES   = DEF_SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick16_i,
  input  logic strap_ir_i,
  input  logic cfg_mode_we_i,
  input  logic cfg_mode_i,
  input  logic cfg_rx_inv_i,
  input  logic cfg_half_dup_i,
  input  logic tx_busy_i,
  input  logic uart_txd_i,
  output logic uart_rxd_o,
  output logic pin_txd_o,
  input  logic pin_rxd_i,
  output logic mode_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  line_mode_e mode;
  logic       ir_on;
  logic       blank;
  logic       enc_pulse;
  logic       dec_bit;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  irls_mode_ctl u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .strap_i (strap_ir_i),
    .wr_en_i (cfg_mode_we_i),
    .wr_val_i(cfg_mode_i),
    .mode_o  (mode)
  );

  assign ir_on = (mode == LINE_IR);
  assign blank = ir_on && cfg_half_dup_i && tx_busy_i;

  irls_pulse_enc #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .PULSE_START  (PULSE_START),
    .PULSE_LEN    (PULSE_LEN)
  ) u_enc (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .en_i   (ir_on),
    .tick_i (tick16_i),
    .bit_i  (uart_txd_i),
    .pulse_o(enc_pulse)
  );

  irls_pulse_dec #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .SYNC_STAGES  (SYNC_STAGES)
  ) u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .en_i   (ir_on),
    .blank_i(blank),
    .tick_i (tick16_i),
    .line_i (pin_rxd_i ^ cfg_rx_inv_i),
    .bit_o  (dec_bit)
  );

  always_comb begin
    if (ir_on) begin
      pin_txd_o  = enc_pulse;
      uart_rxd_o = blank ? 1'b1 : dec_bit;
    end else begin
      pin_txd_o  = uart_txd_i;
      uart_rxd_o = pin_rxd_i;
    end
  end

  assign mode_o = ir_on;
endmodule

// File: rtl/irls_checker.sv
`timescale 1ns/1ps
module irls_checker #(
  parameter int PULSE_LEN = irls_pkg::DEF_PULSE_LEN
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tick16_i,
  input logic strap_ir_i,
  input logic cfg_mode_we_i,
  input logic cfg_mode_i,
  input logic cfg_half_dup_i,
  input logic tx_busy_i,
  input logic uart_txd_i,
  input logic uart_rxd_o,
  input logic pin_txd_o,
  input logic pin_rxd_i,
  input logic mode_o
);
  logic [1:0] cyc_q;
  logic [7:0] hi_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q    <= '0;
      hi_cnt_q <= '0;
    end else begin
      if (cyc_q != 2'd2) cyc_q <= cyc_q + 2'd1;
      if (!mode_o || !pin_txd_o) hi_cnt_q <= '0;
      else if (tick16_i && hi_cnt_q != 8'hFF) hi_cnt_q <= hi_cnt_q + 8'd1;
    end
  end

  // R1
  strap_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd1 && !$past(cfg_mode_we_i)) |-> (mode_o == strap_ir_i));

  // R2
  mode_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cfg_mode_we_i) |-> (mode_o == $past(cfg_mode_i)));

  // R3
  direct_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_o |-> (uart_rxd_o == pin_rxd_i));

  // R4
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_cnt_q <= 8'(PULSE_LEN));

  // R5
  ir_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o && $past(mode_o) && $past(tick16_i) && $past(uart_txd_i)) |-> !pin_txd_o);

  // R9
  blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o && cfg_half_dup_i && tx_busy_i) |-> uart_rxd_o);

  // R10
  cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mode_o) |-> (pin_txd_o == uart_txd_i));
endmodule

bind ir_line_switch irls_checker #(.PULSE_LEN(PULSE_LEN)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_n_int),
  .tick16_i      (tick16_i),
  .strap_ir_i    (strap_ir_i),
  .cfg_mode_we_i (cfg_mode_we_i),
  .cfg_mode_i    (cfg_mode_i),
  .cfg_half_dup_i(cfg_half_dup_i),
  .tx_busy_i     (tx_busy_i),
  .uart_txd_i    (uart_txd_i),
  .uart_rxd_o    (uart_rxd_o),
  .pin_txd_o     (pin_txd_o),
  .pin_rxd_i     (pin_rxd_i),
  .mode_o        (mode_o)
);

// File: tb/ir_line_switch_tb_top.sv
`timescale 1ns/1ps
module ir_line_switch_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic strap = 1'b0;
  logic we = 1'b0;
  logic wval = 1'b0;
  logic inv = 1'b0;
  logic hdup = 1'b0;
  logic busy = 1'b0;
  logic utx = 1'b1;
  logic urx;
  logic ptx;
  logic prx = 1'b0;
  logic mode;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ir_line_switch dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick), .strap_ir_i(strap),
    .cfg_mode_we_i(we), .cfg_mode_i(wval), .cfg_rx_inv_i(inv),
    .cfg_half_dup_i(hdup), .tx_busy_i(busy), .uart_txd_i(utx),
    .uart_rxd_o(urx), .pin_txd_o(ptx), .pin_rxd_i(prx), .mode_o(mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset(input logic s);
    rst_n = 1'b0; strap = s; we = 1'b0; inv = 1'b0; hdup = 1'b0;
    busy = 1'b0; utx = 1'b1; prx = 1'b0; tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic write_mode(input logic v);
    @(negedge clk) begin we = 1'b1; wval = v; end
    @(negedge clk) we = 1'b0;
  endtask

  task automatic t_reset_direct();
    do_reset(1'b0);
    chk("R1 mode after reset, strap 0", 32'(mode), 0);
    utx = 1'b0; @(negedge clk);
    chk("R3 direct tx low", 32'(ptx), 0);
    utx = 1'b1; @(negedge clk);
    chk("R3 direct tx high", 32'(ptx), 1);
    prx = 1'b1; #1;
    chk("R3 direct rx high", 32'(urx), 1);
    prx = 1'b0; #1;
    chk("R3 direct rx low", 32'(urx), 0);
    do_reset(1'b1);
    chk("R1 mode after reset, strap 1", 32'(mode), 1);
    chk("R5 idle tx pin after reset", 32'(ptx), 0);
  endtask

  task automatic t_override();
    do_reset(1'b1);
    write_mode(1'b0);
    chk("R2 write 0 over strap 1", 32'(mode), 0);
    write_mode(1'b1);
    chk("R2 write 1", 32'(mode), 1);
    do_reset(1'b0);
    write_mode(1'b1);
    chk("R2 write 1 over strap 0", 32'(mode), 1);
  endtask

  task automatic t_encode(input logic [7:0] data);
    logic [10:0] frame;
    int idle_hi;
    frame = {1'b1, 1'b1, data, 1'b0};
    utx = 1'b1;
    idle_hi = 0;
    for (int i = 0; i < 20; i++) begin
      step_tick();
      if (ptx) idle_hi++;
    end
    chk("R5 idle line gives no pulse", 32'(idle_hi), 0);
    for (int c = 0; c < 11; c++) begin
      int mism;
      mism = 0;
      utx = frame[c];
      for (int k = 0; k < 16; k++) begin
        logic e;
        step_tick();
        e = !frame[c] && (k >= 8) && (k <= 10);
        if (ptx !== e) mism++;
      end
      chk($sformatf("R4 cell %0d of byte %0h pulse shape", c, data), 32'(mism), 0);
    end
  endtask

  task automatic t_decode(input logic invert, input string req);
    logic [9:0] bits;
    logic prev_bit;
    bits = 10'b1000110010;
    inv = invert;
    prx = invert;
    for (int i = 0; i < 20; i++) step_tick();
    chk({req, " idle output"}, 32'(urx), 1);
    prev_bit = 1'b1;
    for (int c = 0; c < 12; c++) begin
      logic b;
      int mism;
      b = (c < 10) ? bits[c] : 1'b1;
      mism = 0;
      for (int k = 0; k < 16; k++) begin
        logic e;
        prx = invert ^ (!b && k < 3);
        step_tick();
        e = (k >= 1) ? b : prev_bit;
        if (urx !== e) mism++;
      end
      chk($sformatf("%s decode cell %0d", req, c), 32'(mism), 0);
      prev_bit = b;
    end
    prx = invert;
    inv = 1'b0;
    prx = 1'b0;
    for (int i = 0; i < 4; i++) step_tick();
  endtask

  task automatic zero_cell_lows(output int lows);
    lows = 0;
    for (int k = 0; k < 16; k++) begin
      prx = (k < 3);
      step_tick();
      if (!urx) lows++;
    end
    prx = 1'b0;
    for (int i = 0; i < 20; i++) step_tick();
  endtask

  task automatic t_half_duplex();
    int lows;
    hdup = 1'b1; busy = 1'b1;
    zero_cell_lows(lows);
    chk("R9 blanked while busy", 32'(lows), 0);
    busy = 1'b0;
    zero_cell_lows(lows);
    chk("R9 decodes when not busy", 32'(lows), 15);
    hdup = 1'b0; busy = 1'b1;
    zero_cell_lows(lows);
    chk("R9 busy ignored without half duplex", 32'(lows), 15);
    busy = 1'b0; hdup = 1'b1;
    for (int k = 0; k < 5; k++) begin
      prx = (k < 3);
      step_tick();
    end
    chk("R6 held low before blanking", 32'(urx), 0);
    busy = 1'b1; #1;
    chk("R9 forced high at once", 32'(urx), 1);
    @(negedge clk) busy = 1'b0; #1;
    chk("R9 held bit discarded", 32'(urx), 1);
    hdup = 1'b0;
    for (int i = 0; i < 20; i++) step_tick();
  endtask

  task automatic t_cancel();
    int hi;
    utx = 1'b1;
    for (int i = 0; i < 20; i++) step_tick();
    utx = 1'b0;
    for (int k = 0; k < 9; k++) step_tick();
    chk("R4 pulse active at index 8", 32'(ptx), 1);
    write_mode(1'b0);
    chk("R10 cleared mode follows txd", 32'(ptx), 0);
    utx = 1'b1; #1;
    chk("R10 direct after cancel", 32'(ptx), 1);
    write_mode(1'b1);
    chk("R10 re-enter idle pin low", 32'(ptx), 0);
    hi = 0;
    for (int i = 0; i < 20; i++) begin
      step_tick();
      if (ptx) hi++;
    end
    chk("R10 no pulse after re-enter", 32'(hi), 0);
  endtask

  initial begin
    t_reset_direct();
    t_override();
    do_reset(1'b1);
    t_encode(8'hA5);
    t_encode(8'h00);
    t_encode(8'hFF);
    t_decode(1'b0, "R6 R7");
    t_decode(1'b1, "R8");
    t_half_duplex();
    t_cancel();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule